// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block performs the stack-frame work of a 32-bit stack-based processor when it calls a subroutine, returns from one, or enters a software interrupt. The decoder hands it one command with the current instruction address, an argument word and the present frame pointer (FP) and stack pointer (SP). The block then runs the word-wide memory accesses one at a time over a request/acknowledge port. When the sequence ends it pulses `done` and presents the new FP, SP and program counter for the register file and fetch unit to take in that cycle.

A call frame holds three words. Going downward from the caller's SP they are an empty reserved slot, the return address and the caller's FP. When a call completes, FP and SP both point at the saved FP word. A return walks the same frame upward, starting from FP rather than SP. A software interrupt always reports its cause and number through a special-register write strobe. For the all-ones interrupt number it also runs the full call sequence into a handler address supplied from a special register.

Top module: `frame_seq`

## Requirements
- R1: Command encoding on `cmd_op`: 2'b00 call with absolute target, 2'b01 call with register target, 2'b10 return, 2'b11 software interrupt. For calls, `cmd_arg` is the target. An absolute call stores return address `cmd_pc`+6.
- R2: A register-target call stores return address `cmd_pc`+2. Both call forms write exactly two words: the return address at SP_in-8, then FP_in at SP_in-12. The reserved word at SP_in-4 is never written.
- R3: At the `done` of any call, `fp_out` and `sp_out` both equal SP_in-12 and `pc_out` equals the target.
- R4: A return reads FP_in first and then FP_in+4, with no writes and with SP_in ignored. At `done`, `fp_out` is the first word read, `pc_out` is the second word read and `sp_out` is FP_in+12.
- R5: A software interrupt whose number (`cmd_arg`) is not 0xFFFFFFFF makes no memory access. At `done` it raises `exc_we` with `exc_cause`=3 and `exc_num`=`cmd_arg`, leaves `fp_out`/`sp_out` equal to FP_in/SP_in and sets `pc_out` to `cmd_pc`+6.
- R6: A software interrupt with number 0xFFFFFFFF runs the call sequence with target `handler_in` and return address `cmd_pc`+6. It also raises `exc_we` with cause 3 and number 0xFFFFFFFF at `done`.
- R7: Each access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is high. The sequence advances only on that cycle, for any acknowledge latency.
- R8: `done` is high for exactly one cycle, only after the last memory access has completed. `busy` is high from the cycle after acceptance through the `done` cycle.
- R9: `cmd_valid` raised while `busy` is high is ignored: it does not change the accesses or the results of the sequence in progress, and no further sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_op | input | 2 | Command code, see R1 |
| cmd_pc | input | 32 | Address of the issuing instruction |
| cmd_arg | input | 32 | Call target or interrupt number |
| handler_in | input | 32 | Handler address for the all-ones interrupt |
| fp_in | input | 32 | Current frame pointer |
| sp_in | input | 32 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fp_out | output | 32 | New frame pointer, valid with done |
| sp_out | output | 32 | New stack pointer, valid with done |
| pc_out | output | 32 | New program counter, valid with done |
| exc_we | output | 1 | Special-register write strobe for interrupt entry |
| exc_cause | output | 32 | Cause value written (3) |
| exc_num | output | 32 | Interrupt number written |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |

## Verification
The bench pre-fills the reserved slot with a marker and checks it afterwards. A design that pushed the return address without first skipping that slot would overwrite the marker and leave FP/SP four bytes high. A return is run over the frame a call just built, with a bogus SP input. A design that unwound from SP, or that forgot the extra skip, would read the wrong words or give an SP short by four. The two return-address offsets and both software-interrupt paths are checked separately; an off-by-four on the all-ones entry or a stray access on a plain interrupt would show up. Nonzero acknowledge latencies and a command poked mid-sequence expose a design that advances early or restarts, because extra writes or changed results would appear.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int XLEN = 32,
  parameter int WB   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [XLEN-1:0] cmd_pc,
  input  logic [XLEN-1:0] cmd_arg,
  input  logic [XLEN-1:0] handler_in,
  input  logic [XLEN-1:0] fp_in,
  input  logic [XLEN-1:0] sp_in,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] fp_out,
  output logic [XLEN-1:0] sp_out,
  output logic [XLEN-1:0] pc_out,
  output logic            exc_we,
  output logic [XLEN-1:0] exc_cause,
  output logic [XLEN-1:0] exc_num,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ack
);
  localparam logic [XLEN-1:0] STEP   = XLEN'(WB);
  localparam logic [XLEN-1:0] STEP2  = XLEN'(2 * WB);
  localparam logic [XLEN-1:0] LONGRA = XLEN'(6);
  localparam logic [XLEN-1:0] SHORTRA = XLEN'(2);
  localparam logic [XLEN-1:0] ALL1   = '1;

  typedef enum logic [2:0] {S_IDLE, S_WRA, S_WFP, S_RFP, S_RRA, S_FIN} st_t;

  st_t st;
  logic [XLEN-1:0] sp_w, fp_r, pc_r, ra_r, num_r;
  logic swi_r, fr_r, call_r;

  wire take = cmd_valid && (st == S_IDLE);
  wire hit  = mem_req && mem_ack;
  wire lnx  = (cmd_arg == ALL1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sp_w <= '0; fp_r <= '0; pc_r <= '0; ra_r <= '0; num_r <= '0;
      swi_r <= 1'b0; fr_r <= 1'b0; call_r <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          swi_r  <= (cmd_op == 2'b11);
          num_r  <= cmd_arg;
          fr_r   <= (cmd_op != 2'b11) || lnx;
          call_r <= (cmd_op == 2'b00) || (cmd_op == 2'b01) || (cmd_op == 2'b11 && lnx);
          fp_r   <= fp_in;
          case (cmd_op)
            2'b00: begin ra_r <= cmd_pc + LONGRA;  pc_r <= cmd_arg;
                         sp_w <= sp_in - STEP2; st <= S_WRA; end
            2'b01: begin ra_r <= cmd_pc + SHORTRA; pc_r <= cmd_arg;
                         sp_w <= sp_in - STEP2; st <= S_WRA; end
            2'b10: begin sp_w <= fp_in; st <= S_RFP; end
            default: begin
              if (lnx) begin
                ra_r <= cmd_pc + LONGRA; pc_r <= handler_in;
                sp_w <= sp_in - STEP2;   st <= S_WRA;
              end else begin
                pc_r <= cmd_pc + LONGRA; sp_w <= sp_in; st <= S_FIN;
              end
            end
          endcase
        end
        S_WRA: if (hit) begin sp_w <= sp_w - STEP; st <= S_WFP; end
        S_WFP: if (hit) begin fp_r <= sp_w; st <= S_FIN; end
        S_RFP: if (hit) begin fp_r <= mem_rdata; sp_w <= sp_w + STEP; st <= S_RRA; end
        S_RRA: if (hit) begin pc_r <= mem_rdata; sp_w <= sp_w + STEP2; st <= S_FIN; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_WRA) || (st == S_WFP) || (st == S_RFP) || (st == S_RRA);
  assign mem_we    = (st == S_WRA) || (st == S_WFP);
  assign mem_addr  = sp_w;
  assign mem_wdata = (st == S_WRA) ? ra_r : fp_r;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign fp_out    = fp_r;
  assign sp_out    = sp_w;
  assign pc_out    = pc_r;
  assign exc_we    = done && swi_r;
  assign exc_cause = XLEN'(3);
  assign exc_num   = num_r;

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    done && fr_r |-> $past(mem_req && mem_ack));

  a_r3_frame_points_equal: assert property (@(posedge clk) disable iff (!rst_n)
    done && call_r |-> fp_out == sp_out);

  a_r4_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RRA) && ($past(st) == S_RFP) |-> mem_addr == $past(mem_addr) + STEP);

  a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WFP) && ($past(st) == S_WRA) |-> mem_addr == $past(mem_addr) - STEP);
endmodule

// File: tb/frame_seq_tb.sv
module frame_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [31:0] cmd_pc = '0, cmd_arg = '0, handler_in = '0, fp_in = '0, sp_in = '0;
  logic busy, done, exc_we, mem_req, mem_we, mem_ack;
  logic [31:0] fp_out, sp_out, pc_out, exc_cause, exc_num, mem_addr, mem_wdata, mem_rdata;

  int nchk = 0, nfail = 0;
  int lat = 0, wcnt = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [31:0] wr_a [0:15];
  logic [31:0] wr_d [0:15];
  logic [31:0] rd_a [0:15];
  logic [31:0] mem [0:255];
  logic [31:0] c_fp, c_sp, c_pc, c_cause, c_num;
  logic c_exc;
  int wb, rb;

  always #10 clk = ~clk;

  frame_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pc(cmd_pc), .cmd_arg(cmd_arg), .handler_in(handler_in),
    .fp_in(fp_in), .sp_in(sp_in), .busy(busy), .done(done),
    .fp_out(fp_out), .sp_out(sp_out), .pc_out(pc_out), .exc_we(exc_we),
    .exc_cause(exc_cause), .exc_num(exc_num), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  assign mem_ack   = mem_req && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      wcnt <= 0;
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        if (wr_cnt < 16) begin wr_a[wr_cnt] <= mem_addr; wr_d[wr_cnt] <= mem_wdata; end
        wr_cnt <= wr_cnt + 1;
      end else begin
        if (rd_cnt < 16) rd_a[rd_cnt] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end else if (mem_req) wcnt <= wcnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [31:0] pc, input logic [31:0] arg,
                     input logic [31:0] fp, input logic [31:0] sp, input bit poke);
    int n;
    @(negedge clk);
    wb = wr_cnt; rb = rd_cnt;
    cmd_op = op; cmd_pc = pc; cmd_arg = arg; fp_in = fp; sp_in = sp; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      if (poke && n < 3) begin
        cmd_op = 2'b10; fp_in = 32'h0; sp_in = 32'h0; cmd_pc = 32'h0; cmd_arg = 32'h0;
        cmd_valid = 1'b1;
      end else cmd_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    cmd_valid = 1'b0;
    chk(done, "R8 done reached", {31'b0, done}, 32'h1);
    c_fp = fp_out; c_sp = sp_out; c_pc = pc_out;
    c_exc = exc_we; c_cause = exc_cause; c_num = exc_num;
    chk(busy, "R8 busy during done", {31'b0, busy}, 32'h1);
    @(negedge clk);
    chk(!done, "R8 done single cycle", {31'b0, done}, 32'h0);
  endtask

  task automatic t_reset;
    chk(!done, "R8 reset done", {31'b0, done}, 32'h0);
    chk(!busy, "R8 reset busy", {31'b0, busy}, 32'h0);
    chk(!mem_req, "R7 reset req", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_call_abs;
    lat = 0;
    run(2'b00, 32'h100, 32'h4000, 32'h300, 32'h280, 1'b0);
    chk(wr_cnt - wb == 2, "R2 write count", 32'(wr_cnt - wb), 32'd2);
    chk(rd_cnt == rb, "R2 no reads", 32'(rd_cnt - rb), 32'd0);
    chk(wr_a[wb] == 32'h278, "R2 ra addr", wr_a[wb], 32'h278);
    chk(wr_d[wb] == 32'h106, "R1 ra value", wr_d[wb], 32'h106);
    chk(wr_a[wb+1] == 32'h274, "R2 fp addr", wr_a[wb+1], 32'h274);
    chk(wr_d[wb+1] == 32'h300, "R2 fp value", wr_d[wb+1], 32'h300);
    chk(mem[8'h9F] == 32'hA5A5_0000 + 32'h9F, "R2 reserved slot", mem[8'h9F], 32'hA5A5_009F);
    chk(c_fp == 32'h274, "R3 fp", c_fp, 32'h274);
    chk(c_sp == 32'h274, "R3 sp", c_sp, 32'h274);
    chk(c_pc == 32'h4000, "R3 pc", c_pc, 32'h4000);
    chk(!c_exc, "R3 no exc", {31'b0, c_exc}, 32'h0);
  endtask

  task automatic t_return;
    lat = 2;
    run(2'b10, 32'h5000, 32'h0, 32'h274, 32'h1000, 1'b0);
    chk(wr_cnt == wb, "R4 no writes", 32'(wr_cnt - wb), 32'd0);
    chk(rd_cnt - rb == 2, "R4 read count", 32'(rd_cnt - rb), 32'd2);
    chk(rd_a[rb] == 32'h274, "R4 first read", rd_a[rb], 32'h274);
    chk(rd_a[rb+1] == 32'h278, "R4 second read", rd_a[rb+1], 32'h278);
    chk(c_fp == 32'h300, "R4 fp", c_fp, 32'h300);
    chk(c_pc == 32'h106, "R4 pc", c_pc, 32'h106);
    chk(c_sp == 32'h280, "R4 sp", c_sp, 32'h280);
  endtask

  task automatic t_call_reg;
    lat = 3;
    run(2'b01, 32'h200, 32'h5000, 32'h3F0, 32'h3E0, 1'b0);
    chk(wr_cnt - wb == 2, "R7 write count with latency", 32'(wr_cnt - wb), 32'd2);
    chk(wr_a[wb] == 32'h3D8 && wr_d[wb] == 32'h202, "R2 reg-call ra", wr_d[wb], 32'h202);
    chk(wr_a[wb+1] == 32'h3D4 && wr_d[wb+1] == 32'h3F0, "R2 reg-call fp", wr_d[wb+1], 32'h3F0);
    chk(c_fp == 32'h3D4 && c_sp == 32'h3D4, "R3 reg-call frame", c_sp, 32'h3D4);
    chk(c_pc == 32'h5000, "R3 reg-call pc", c_pc, 32'h5000);
  endtask

  task automatic t_swi_plain;
    lat = 0;
    run(2'b11, 32'h40, 32'h5, 32'h111, 32'h222, 1'b0);
    chk(wr_cnt == wb && rd_cnt == rb, "R5 no access", 32'(wr_cnt - wb + rd_cnt - rb), 32'd0);
    chk(c_exc, "R5 exc_we", {31'b0, c_exc}, 32'h1);
    chk(c_cause == 32'd3, "R5 cause", c_cause, 32'd3);
    chk(c_num == 32'd5, "R5 num", c_num, 32'd5);
    chk(c_fp == 32'h111 && c_sp == 32'h222, "R5 fp/sp kept", c_sp, 32'h222);
    chk(c_pc == 32'h46, "R5 pc", c_pc, 32'h46);
  endtask

  task automatic t_swi_all1;
    lat = 1;
    handler_in = 32'h7000;
    run(2'b11, 32'h80, 32'hFFFF_FFFF, 32'h1F0, 32'h1C0, 1'b0);
    chk(wr_cnt - wb == 2, "R6 write count", 32'(wr_cnt - wb), 32'd2);
    chk(wr_a[wb] == 32'h1B8 && wr_d[wb] == 32'h86, "R6 ra", wr_d[wb], 32'h86);
    chk(wr_a[wb+1] == 32'h1B4 && wr_d[wb+1] == 32'h1F0, "R6 fp push", wr_d[wb+1], 32'h1F0);
    chk(c_fp == 32'h1B4 && c_sp == 32'h1B4, "R6 frame", c_sp, 32'h1B4);
    chk(c_pc == 32'h7000, "R6 handler pc", c_pc, 32'h7000);
    chk(c_exc && c_cause == 32'd3, "R6 cause", c_cause, 32'd3);
    chk(c_num == 32'hFFFF_FFFF, "R6 num", c_num, 32'hFFFF_FFFF);
  endtask

  task automatic t_refuse;
    lat = 4;
    run(2'b01, 32'h10, 32'h900, 32'h150, 32'h140, 1'b1);
    chk(wr_cnt - wb == 2 && rd_cnt == rb, "R9 accesses unchanged", 32'(wr_cnt - wb), 32'd2);
    chk(wr_d[wb] == 32'h12 && wr_d[wb+1] == 32'h150, "R9 pushed data", wr_d[wb], 32'h12);
    chk(c_fp == 32'h134 && c_sp == 32'h134 && c_pc == 32'h900, "R9 result", c_sp, 32'h134);
    repeat (6) @(negedge clk);
    chk(!busy && !done, "R9 no second sequence", {31'b0, busy}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5A5_0000 + 32'(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_call_abs();
    t_return();
    t_call_reg();
    t_swi_plain();
    t_swi_all1();
    t_refuse();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule